// File: doc/BRIEF.md
# Prioritized Chip-Select Decoder with Boot Mode

This block watches a 32-bit address bus and drives up to four active-low select lines. Each select line is set up by two configuration words. The base word holds the address tag, the function-code tag, a write-protect flag and an enable flag. The mask word holds the "don't care" bits for the address and for the function code, a port-size flag and a wait-state count. A bus cycle begins when address strobe is sampled low. The block then picks the lowest-numbered enabled select that matches, asserts it and, after the programmed number of wait states, drives the acknowledge that matches the port size (8-bit or 16-bit).

Reset places the block in boot mode. In boot mode select 0 answers every access as a 16-bit port with three wait states. It ignores protection and function codes. All other select lines are held off. Boot mode ends for good the first time the enable flag of select 0's base word is written as 1. After that, select 0 decodes only the range that was loaded into it. An external 8-bit acknowledge that arrives before the internal acknowledge ends the cycle as an 8-bit transfer, and the internal acknowledge stays quiet for the rest of that cycle.

Top module: `csel_decoder`

## Requirements
- R1: After reset all select lines, both acknowledges and the bus-error output are high (negated), and the block is in boot mode.
- R2: In boot mode, every cycle asserts select 0 from the edge that samples address strobe low (edge 0), for any address, function code and direction, and asserts the 16-bit acknowledge after edge 3.
- R3: In boot mode, select lines 1 to 3 never assert, whatever their configuration words hold.
- R4: Writing 1 to bit 0 (enable) of select 0's base word ends boot mode. From then on select 0 decodes only its loaded range, and the other selects decode normally.
- R5: No configuration write restarts boot mode. Writing select 0's base word with enable 0 simply disables select 0.
- R6: Select i matches when ((addr ^ base) & ~mask) is zero over address bits 31..8, and ((fc ^ base[7:5]) & ~mask[7:5]) is zero. Mask bits set to 1 are ignored. Only selects whose enable bit is 1 take part.
- R7: When several enabled selects match, only the lowest-numbered one asserts.
- R8: Mask bits [1:0] give the wait-state count N (0 to 3), and the acknowledge asserts after edge N. Mask bit 2 picks the port: 1 gives the 16-bit acknowledge and 0 gives the 8-bit one. The acknowledge stays asserted until release.
- R9: Outside boot mode, a write cycle (rw=0) whose winning select has base bit 1 (write-protect) set asserts no select and no acknowledge. It drives bus error low instead. A read of the same select is served normally.
- R10: Outside boot mode, when no enabled select matches, no select, no acknowledge and no bus error is asserted.
- R11: If the external 8-bit acknowledge is sampled low at an edge k of the cycle with 1 ≤ k ≤ N, the internal acknowledge stays negated for the rest of the cycle. Once the internal acknowledge has appeared, later external acknowledges have no effect.
- R12: The edge that samples address strobe high negates every select, both acknowledges and bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; restores boot mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select index being written |
| cfg_reg | input | 1 | 0 = base word, 1 = mask word |
| cfg_wdata | input | 32 | Configuration word |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 32 | Bus address |
| fc | input | 3 | Function code of the cycle |
| rw | input | 1 | 1 = read, 0 = write |
| ext_ack8_n | input | 1 | External 8-bit acknowledge, active low |
| cs_n | output | 4 | Select lines, active low |
| ack8_n | output | 1 | Internal 8-bit acknowledge, active low |
| ack16_n | output | 1 | Internal 16-bit acknowledge, active low |
| berr_n | output | 1 | Bus error on protected write, active low |

## Verification
The bench builds the block with its defaults: four selects, a 32-bit address, an 8-bit address granule and a boot wait count of 3. With four selects, every priority pairing and a full stack of overlapping ranges can be set up. The 2-bit wait field lets the bench reach both extremes, 0 and 3. At 0 the acknowledge is already out and an external acknowledge cannot preempt it. At 3 external acknowledges at edges 1 to 3 are all suppressing, and one at edge 4 comes too late.

// File: rtl/csel_pkg.sv
package csel_pkg;
   // configuration word field positions (shared by base and mask words)
   localparam int CFG_VALID_BIT = 0;   // base word: enable
   localparam int CFG_WP_BIT    = 1;   // base word: write protect
   localparam int CFG_SIZE_BIT  = 2;   // mask word: 1 = 16-bit port
   localparam int CFG_WS_LSB    = 0;   // mask word: wait-state count
   localparam int CFG_FC_LSB    = 5;   // both words: function-code field
   localparam int FC_W          = 3;
   localparam int WS_W          = 2;
   localparam logic CFG_BASE    = 1'b0;
   localparam logic CFG_MASK    = 1'b1;

   typedef struct packed {
      logic            valid;
      logic            wp;
      logic            size16;
      logic [WS_W-1:0] ws;
   } sel_ctl_t;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
   import csel_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int N_SEL   = 4,
   parameter int CMP_LSB = 8,
   localparam int IDX_W  = $clog2(N_SEL),
   localparam int TAG_W  = ADDR_W - CMP_LSB
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IDX_W-1:0]            wsel,
   input  logic                        wreg,
   input  logic [ADDR_W-1:0]           wdata,
   output logic [N_SEL-1:0][TAG_W-1:0] base_tag,
   output logic [N_SEL-1:0][TAG_W-1:0] mask_tag,
   output logic [N_SEL-1:0][FC_W-1:0]  base_fc,
   output logic [N_SEL-1:0][FC_W-1:0]  mask_fc,
   output sel_ctl_t [N_SEL-1:0]        ctl,
   output logic                        global_mode
);
   logic unused_wdata;
   assign unused_wdata = ^wdata[CFG_FC_LSB-1:CFG_SIZE_BIT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_tag <= '0;
         mask_tag <= '0;
         base_fc  <= '0;
         mask_fc  <= '0;
         ctl      <= '0;
      end else if (we) begin
         for (int i = 0; i < N_SEL; i++) begin
            if (wsel == IDX_W'(i)) begin
               if (wreg == CFG_BASE) begin
                  base_tag[i]  <= wdata[ADDR_W-1:CMP_LSB];
                  base_fc[i]   <= wdata[CFG_FC_LSB +: FC_W];
                  ctl[i].wp    <= wdata[CFG_WP_BIT];
                  ctl[i].valid <= wdata[CFG_VALID_BIT];
               end else begin
                  mask_tag[i]   <= wdata[ADDR_W-1:CMP_LSB];
                  mask_fc[i]    <= wdata[CFG_FC_LSB +: FC_W];
                  ctl[i].size16 <= wdata[CFG_SIZE_BIT];
                  ctl[i].ws     <= wdata[CFG_WS_LSB +: WS_W];
               end
            end
         end
      end
   end

   // boot mode: set only by reset, left on first enable of select 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         global_mode <= 1'b1;
      else if (we && wsel == '0 && wreg == CFG_BASE && wdata[CFG_VALID_BIT])
         global_mode <= 1'b0;
   end
endmodule

// File: rtl/csel_match.sv
module csel_match
   import csel_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int N_SEL   = 4,
   parameter int CMP_LSB = 8,
   localparam int TAG_W  = ADDR_W - CMP_LSB
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [FC_W-1:0]             fc,
   input  logic [N_SEL-1:0][TAG_W-1:0] base_tag,
   input  logic [N_SEL-1:0][TAG_W-1:0] mask_tag,
   input  logic [N_SEL-1:0][FC_W-1:0]  base_fc,
   input  logic [N_SEL-1:0][FC_W-1:0]  mask_fc,
   input  sel_ctl_t [N_SEL-1:0]        ctl,
   output logic [N_SEL-1:0]            hit
);
   logic unused_low_addr;
   assign unused_low_addr = ^addr[CMP_LSB-1:0];

   for (genvar g = 0; g < N_SEL; g++) begin : g_cmp
      logic tag_ok, fc_ok;
      assign tag_ok = ((addr[ADDR_W-1:CMP_LSB] ^ base_tag[g]) & ~mask_tag[g]) == '0;
      assign fc_ok  = ((fc ^ base_fc[g]) & ~mask_fc[g]) == '0;
      assign hit[g] = ctl[g].valid & tag_ok & fc_ok;
   end
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
   parameter int N_SEL  = 4,
   localparam int IDX_W = $clog2(N_SEL)
) (
   input  logic [N_SEL-1:0] hit,
   output logic [IDX_W-1:0] win,
   output logic             any
);
   // scan downward so the lowest index is written last and wins
   always_comb begin
      win = '0;
      any = 1'b0;
      for (int i = N_SEL - 1; i >= 0; i--) begin
         if (hit[i]) begin
            win = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/csel_timing.sv
module csel_timing
   import csel_pkg::*;
#(
   parameter int N_SEL = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            as_n,
   input  logic            ext_ack8_n,
   input  logic [N_SEL-1:0] req_sel,
   input  logic            req_ack,
   input  logic            req_size16,
   input  logic [WS_W-1:0] req_ws,
   input  logic            req_berr,
   output logic [N_SEL-1:0] cs_n,
   output logic            ack8_n,
   output logic            ack16_n,
   output logic            berr_n
);
   logic             active, supp, go_q, size_q, berr_q;
   logic [N_SEL-1:0] sel_q;
   logic [WS_W-1:0]  ws_q, cnt;
   logic             ack_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; supp <= 1'b0; go_q <= 1'b0; size_q <= 1'b0;
         berr_q <= 1'b0; sel_q <= '0; ws_q <= '0; cnt <= '0;
      end else if (as_n) begin
         active <= 1'b0; supp <= 1'b0; go_q <= 1'b0;
         berr_q <= 1'b0; sel_q <= '0; cnt <= '0;
      end else if (!active) begin
         active <= 1'b1;
         supp   <= 1'b0;
         sel_q  <= req_sel;
         go_q   <= req_ack;
         size_q <= req_size16;
         ws_q   <= req_ws;
         berr_q <= req_berr;
         cnt    <= '0;
      end else if (cnt != ws_q) begin
         cnt <= cnt + 1'b1;
         if (!ext_ack8_n) supp <= 1'b1;
      end
   end

   assign ack_now = active & go_q & ~supp & (cnt == ws_q);
   assign cs_n    = ~sel_q;
   assign ack16_n = ~(ack_now & size_q);
   assign ack8_n  = ~(ack_now & ~size_q);
   assign berr_n  = ~berr_q;
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
   import csel_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_SEL     = 4,
   parameter int CMP_LSB   = 8,
   parameter int GLOBAL_WS = 3,
   localparam int IDX_W    = $clog2(N_SEL),
   localparam int TAG_W    = ADDR_W - CMP_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic              cfg_reg,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              as_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [FC_W-1:0]   fc,
   input  logic              rw,
   input  logic              ext_ack8_n,
   output logic [N_SEL-1:0]  cs_n,
   output logic              ack8_n,
   output logic              ack16_n,
   output logic              berr_n
);
   if (N_SEL < 2) begin : g_bad_nsel
      $error("N_SEL must be at least 2");
   end
   if (CMP_LSB < CFG_FC_LSB + FC_W || CMP_LSB >= ADDR_W) begin : g_bad_lsb
      $error("CMP_LSB must sit above the function-code field and below ADDR_W");
   end
   if (GLOBAL_WS < 0 || GLOBAL_WS >= (1 << WS_W)) begin : g_bad_ws
      $error("GLOBAL_WS must fit the wait-state field");
   end

   logic [N_SEL-1:0][TAG_W-1:0] base_tag, mask_tag;
   logic [N_SEL-1:0][FC_W-1:0]  base_fc, mask_fc;
   sel_ctl_t [N_SEL-1:0]        ctl;
   logic                        global_mode;
   logic [N_SEL-1:0]            hit;
   logic [IDX_W-1:0]            win;
   logic                        any;
   logic [N_SEL-1:0]            req_sel;
   logic                        req_ack, req_size16, req_berr;
   logic [WS_W-1:0]             req_ws;

   csel_regs #(.ADDR_W(ADDR_W), .N_SEL(N_SEL), .CMP_LSB(CMP_LSB)) i_regs (
      .clk, .rst_n, .we(cfg_we), .wsel(cfg_sel), .wreg(cfg_reg), .wdata(cfg_wdata),
      .base_tag, .mask_tag, .base_fc, .mask_fc, .ctl, .global_mode
   );

   csel_match #(.ADDR_W(ADDR_W), .N_SEL(N_SEL), .CMP_LSB(CMP_LSB)) i_match (
      .addr, .fc, .base_tag, .mask_tag, .base_fc, .mask_fc, .ctl, .hit
   );

   csel_prio #(.N_SEL(N_SEL)) i_prio (.hit, .win, .any);

   always_comb begin
      req_sel    = '0;
      req_ack    = 1'b0;
      req_berr   = 1'b0;
      req_size16 = ctl[win].size16;
      req_ws     = ctl[win].ws;
      if (global_mode) begin
         req_sel[0] = 1'b1;
         req_ack    = 1'b1;
         req_size16 = 1'b1;
         req_ws     = WS_W'(GLOBAL_WS);
      end else if (any) begin
         if (ctl[win].wp && !rw) begin
            req_berr = 1'b1;
         end else begin
            req_sel[win] = 1'b1;
            req_ack      = 1'b1;
         end
      end
   end

   csel_timing #(.N_SEL(N_SEL)) i_timing (
      .clk, .rst_n, .as_n, .ext_ack8_n, .req_sel, .req_ack, .req_size16,
      .req_ws, .req_berr, .cs_n, .ack8_n, .ack16_n, .berr_n
   );
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int N_SEL  = 4,
   localparam int IDX_W = $clog2(N_SEL)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [IDX_W-1:0]  cfg_sel,
   input logic              cfg_reg,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic              as_n,
   input logic [N_SEL-1:0]  cs_n,
   input logic              ack8_n,
   input logic              ack16_n,
   input logic              berr_n,
   input logic              global_mode
);
   // independent record of whether boot mode may still be active
   logic boot_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_seen <= 1'b1;
      else if (cfg_we && cfg_sel == '0 && !cfg_reg && cfg_wdata[0]) boot_seen <= 1'b0;
   end

   a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   a_r3_boot_blocks_others: assert property (@(posedge clk) disable iff (!rst_n)
      boot_seen |-> (&cs_n[N_SEL-1:1]));
   a_r4_boot_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == '0 && !cfg_reg && cfg_wdata[0]) |=> !global_mode);
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !global_mode |=> !global_mode);
   a_r8_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ack8_n && !ack16_n));
   a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && (!ack8_n || !ack16_n)) |=> (!ack8_n || !ack16_n));
   a_r9_berr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !berr_n |-> (&cs_n && ack8_n && ack16_n));
   a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |=> (&cs_n && ack8_n && ack16_n && berr_n));
endmodule

bind csel_decoder csel_decoder_chk #(.ADDR_W(ADDR_W), .N_SEL(N_SEL)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_reg(cfg_reg),
   .cfg_wdata(cfg_wdata), .as_n(as_n), .cs_n(cs_n), .ack8_n(ack8_n),
   .ack16_n(ack16_n), .berr_n(berr_n), .global_mode(global_mode)
);

// File: tb/test_csel_decoder.sv
module test_csel_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_reg = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        as_n = 1'b1;
   logic [31:0] addr = '0;
   logic [2:0]  fc = '0;
   logic        rw = 1'b1;
   logic        ext_ack8_n = 1'b1;
   logic [3:0]  cs_n;
   logic        ack8_n, ack16_n, berr_n;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] bb [4];
   logic [31:0] bm [4];
   logic        glob = 1'b1;

   always #2 clk = ~clk;   // 250 MHz

   csel_decoder i_csel_decoder (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_reg, .cfg_wdata, .as_n, .addr, .fc,
      .rw, .ext_ack8_n, .cs_n, .ack8_n, .ack16_n, .berr_n
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int s, input logic m, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(s); cfg_reg = m; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (m) bm[s] = d;
      else begin
         bb[s] = d;
         if (s == 0 && d[0]) glob = 1'b0;
      end
   endtask

   // expected outcome from the requirements
   task automatic predict(input logic [31:0] a, input logic [2:0] f, input logic r,
                          output logic [3:0] ecs, output int ews, output logic esz,
                          output logic eberr, output logic eack);
      ecs = 4'hF; ews = 0; esz = 1'b0; eberr = 1'b0; eack = 1'b0;
      if (glob) begin
         ecs = 4'b1110; ews = 3; esz = 1'b1; eack = 1'b1;
         return;
      end
      for (int i = 0; i < 4; i++) begin
         if (bb[i][0] && (((a ^ bb[i]) & ~bm[i] & 32'hFFFF_FF00) == 0)
             && (((f ^ bb[i][7:5]) & ~bm[i][7:5]) == 0)) begin
            ews = int'(bm[i][1:0]);
            esz = bm[i][2];
            if (bb[i][1] && !r) eberr = 1'b1;
            else begin
               ecs = ~(4'b0001 << i);
               eack = 1'b1;
            end
            return;
         end
      end
   endtask

   task automatic bus_cycle(input logic [31:0] a, input logic [2:0] f, input logic r,
                            input int ext_k, input string req);
      logic [3:0] ecs, obs_cs;
      int ews, e8, e16, o8, o16;
      logic esz, eberr, eack, obe;
      predict(a, f, r, ecs, ews, esz, eberr, eack);
      e8 = -1; e16 = -1;
      if (eack && !(ext_k >= 1 && ext_k <= ews)) begin
         if (esz) e16 = ews; else e8 = ews;
      end
      o8 = -1; o16 = -1; obe = 1'b0; obs_cs = 4'hF;
      @(negedge clk);
      addr = a; fc = f; rw = r; as_n = 1'b0;
      for (int k = 0; k < 6; k++) begin
         ext_ack8_n = (k == ext_k) ? 1'b0 : 1'b1;
         @(posedge clk);
         @(negedge clk);
         if (k == 0) obs_cs = cs_n;
         if (!ack8_n && o8 < 0) o8 = k;
         if (!ack16_n && o16 < 0) o16 = k;
         if (!berr_n) obe = 1'b1;
      end
      ext_ack8_n = 1'b1;
      as_n = 1'b1;
      check(req, "select lines", int'(obs_cs), int'(ecs));
      check(req, "8-bit ack edge", o8, e8);
      check(req, "16-bit ack edge", o16, e16);
      check(req, "bus error", int'(obe), int'(eberr));
      @(posedge clk);
      @(negedge clk);
      check("R12", "release", int'({cs_n, ack8_n, ack16_n, berr_n}), 7'h7F);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin bb[i] = '0; bm[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset", int'({cs_n, ack8_n, ack16_n, berr_n}), 7'h7F);

      // ranges loaded while in boot mode
      cfg_write(1, 1'b0, 32'h0020_0001);
      cfg_write(1, 1'b1, 32'h0000_FFE5);
      cfg_write(0, 1'b0, 32'h0010_0000);
      cfg_write(0, 1'b1, 32'h000F_FFE6);
      bus_cycle(32'h0020_0040, 3'd1, 1'b1, -1, "R3");
      bus_cycle(32'hDEAD_BE00, 3'd5, 1'b0, -1, "R2");
      bus_cycle(32'h1234_5678, 3'd2, 1'b1, 2, "R11");
      bus_cycle(32'h0000_0004, 3'd6, 1'b1, 3, "R11");
      bus_cycle(32'h8765_4300, 3'd7, 1'b1, 4, "R2");

      // leave boot mode
      cfg_write(0, 1'b0, 32'h0010_0001);
      bus_cycle(32'h0015_0000, 3'd1, 1'b1, -1, "R4");
      bus_cycle(32'h0020_0010, 3'd1, 1'b0, -1, "R4");
      bus_cycle(32'h0900_0000, 3'd1, 1'b1, -1, "R10");

      // disabling select 0 must not bring boot mode back
      cfg_write(0, 1'b0, 32'h0010_0000);
      bus_cycle(32'h0015_0000, 3'd1, 1'b1, -1, "R5");
      bus_cycle(32'h0020_0010, 3'd1, 1'b1, -1, "R5");

      // overlap: select 2 covers select 1's range
      cfg_write(2, 1'b0, 32'h0020_0001);
      cfg_write(2, 1'b1, 32'h00FF_FFE0);
      bus_cycle(32'h0020_0010, 3'd3, 1'b1, -1, "R7");
      bus_cycle(32'h0030_0000, 3'd3, 1'b1, -1, "R8");
      bus_cycle(32'h0030_0000, 3'd3, 1'b1, 1, "R11");

      // write protection
      cfg_write(3, 1'b0, 32'h4000_0003);
      cfg_write(3, 1'b1, 32'h0000_FFE7);
      bus_cycle(32'h4000_1000, 3'd1, 1'b0, -1, "R9");
      bus_cycle(32'h4000_1000, 3'd1, 1'b1, -1, "R9");
      bus_cycle(32'h4000_1000, 3'd1, 1'b1, 4, "R11");

      // function-code qualification
      cfg_write(1, 1'b0, 32'h0020_0041);
      cfg_write(1, 1'b1, 32'h0000_FF05);
      bus_cycle(32'h0020_0010, 3'd2, 1'b1, -1, "R6");
      bus_cycle(32'h0020_0010, 3'd5, 1'b1, -1, "R6");

      // constrained random
      void'($urandom(32'h5EED_0042));
      for (int cfg = 0; cfg < 10; cfg++) begin
         for (int s = 0; s < 4; s++) begin
            logic [31:0] b, m;
            b = ($urandom & 32'hFFFF_FFE0) | (($urandom % 4 == 0) ? 32'h2 : 32'h0)
                | (($urandom % 5 != 0) ? 32'h1 : 32'h0);
            m = ($urandom & $urandom & $urandom & 32'hFFFF_FF00)
                | ($urandom & 32'hE7);
            if (s > 0 && $urandom % 3 == 0) b = {bb[s-1][31:2], b[1:0]};
            cfg_write(s, 1'b1, m);
            cfg_write(s, 1'b0, b);
         end
         for (int n = 0; n < 15; n++) begin
            int j, ek;
            logic [31:0] a;
            logic [2:0] f;
            j = int'($urandom % 4);
            a = (bb[j] & ~bm[j] & 32'hFFFF_FF00) | ($urandom & bm[j] & 32'hFFFF_FF00)
                | ($urandom & 32'hFF);
            f = (bb[j][7:5] & ~bm[j][7:5]) | (3'($urandom) & bm[j][7:5]);
            if ($urandom % 5 == 0) begin a = $urandom; f = 3'($urandom); end
            ek = ($urandom % 6 == 0) ? int'($urandom % 4) + 1 : -1;
            bus_cycle(a, f, 1'($urandom), ek, "R6 R7 R8");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule